// File: doc/BRIEF.md
# Multi-Format Stereo Serial Audio Transmitter

This block takes a stereo pair of 24-bit two's-complement samples from a parallel bus and shifts it out on a three-pin serial audio port. A two-bit format code picks one of three PCM framings or a one-bit stream mode. The PCM framings are left-justified, I2S and right-justified. They differ in the polarity of the frame clock and in where the MSB sits inside a 32-bit channel slot.

In master mode the block divides its system clock down to a bit clock and a frame clock. A three-bit rate code sets the division. In slave mode it follows a bit clock and frame clock from an external controller and drives only the data pin. It learns the slot length from the frame-clock edges, so right-justified data still ends on the last bit of a short slot.

In one-bit stream mode the three pins are reassigned. The frame pin carries the stream clock, the bit-clock pin carries the left bit and the data pin carries the right bit. Format, role and rate are captured only while reset is held.

Top module: `aud_ser_tx`

## Requirements
- R1: While rst_n is low, lrck_o, bck_o and sdata_o read 0 from the first clock edge on.
- R2: In master mode the bit clock period, in system clocks, is set by rate_sel: 000→12, 001→8, 010→6, 011→4, 100→6, 101→4, 110 and 111→2. A frame is 64 bit clocks, split into two 32-bit slots, left first.
- R3: Format code 00 (left-justified): lrck_o is high for the left slot. The MSB is in the first bit period of the slot, followed by the other 23 bits and then 8 zero bits.
- R4: Format code 01 (I2S): lrck_o is low for the left slot. The first bit period carries 0 and the MSB is in the second bit period. The last 7 bit periods carry 0.
- R5: Format code 10 (right-justified): lrck_o is high for the left slot. The LSB is in the last bit period of the slot and all earlier unused bits are 0. The slot length is taken from the previous slot, so a 24-bit slave slot carries the 24 sample bits exactly.
- R6: sdata_o, and lrck_o in master mode, change only in the cycle in which bck_o falls. They are stable while the receiver samples at the rising edge.
- R7: A pair presented with smp_valid is held. The transmitted pair switches only at the start of a left slot, so a pair that arrives during a left slot does not show up in the right slot of the same frame.
- R8: Slave mode (slave_sel=1, format code not 11): clk_oe_o, lrck_o and bck_o read 0. sdata_o follows ext_bck_i and ext_lrck_i, with bit clocks from 48 to 64 per frame. A new slot begins at every frame-clock change seen at a falling bit clock.
- R9: Format code 11 (one-bit stream) always runs as master, even when slave_sel is 1. lrck_o carries a clock with the period of R2. bck_o carries bit 0 of smp_left and sdata_o carries bit 0 of smp_right, both taken at each falling edge of that clock.
- R10: fmt_sel, slave_sel and rate_sel are captured only while rst_n is low. Changes made after release have no effect until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low; configuration is captured while low |
| fmt_sel | input | 2 | Format code: 00 left-justified, 01 I2S, 10 right-justified, 11 one-bit stream |
| slave_sel | input | 1 | 1 selects slave mode for the PCM formats |
| rate_sel | input | 3 | System-clock to sample-rate ratio code for master mode |
| smp_left | input | 24 | Left sample, two's complement (bit 0 is the left stream bit in code 11) |
| smp_right | input | 24 | Right sample, two's complement (bit 0 is the right stream bit in code 11) |
| smp_valid | input | 1 | Loads smp_left and smp_right into the holding pair |
| ext_bck_i | input | 1 | External bit clock in slave mode |
| ext_lrck_i | input | 1 | External frame clock in slave mode |
| lrck_o | output | 1 | Frame clock (master PCM) or stream clock (code 11) |
| bck_o | output | 1 | Bit clock (master PCM) or left stream bit (code 11) |
| sdata_o | output | 1 | Serial PCM data or right stream bit |
| clk_oe_o | output | 1 | 1 when the block drives the clock pins |

## Verification
The hardest case to reach is a right-justified slave frame with 24-bit slots. The slot length is not known until the engine has seen a full slot bounded by two frame-clock edges, and the first falling bit clock after reset only arms the edge detector. The bench drives the external clocks itself with 24 bit clocks per slot for three frames and checks only the last frame. That frame is the first one in which the learned slot length and the latched pair are both in effect. A second corner is a pair loaded halfway through a left slot. The bench injects it from inside its receiver loop at a known bit index, so the slot boundary that must hold it back comes at a known point.

// File: rtl/aud_ser_pkg.sv
package aud_ser_pkg;

   typedef enum logic [1:0] {
      FMT_LJ  = 2'b00,
      FMT_I2S = 2'b01,
      FMT_RJ  = 2'b10,
      FMT_DSD = 2'b11
   } fmt_e;

   typedef struct packed {
      fmt_e       fmt;
      logic       slave;
      logic [2:0] rate;
   } cfg_t;

   localparam int DIV_W = 4;

   // system clocks per sample period for each rate code
   function automatic logic [9:0] ratio_of_code(input logic [2:0] code);
      case (code)
         3'd0:    return 10'd768;
         3'd1:    return 10'd512;
         3'd2:    return 10'd384;
         3'd3:    return 10'd256;
         3'd4:    return 10'd384;
         3'd5:    return 10'd256;
         default: return 10'd128;
      endcase
   endfunction

   // half bit-clock period: ratio / 64 / 2
   function automatic logic [DIV_W-1:0] half_of_code(input logic [2:0] code);
      logic [9:0] r;
      r = ratio_of_code(code);
      return {1'b0, r[9:7]};
   endfunction

   // frame-clock level that marks the left slot
   function automatic logic left_level(input fmt_e f);
      return (f != FMT_I2S);
   endfunction

endpackage

// File: rtl/aud_ser_clkgen.sv
module aud_ser_clkgen
   import aud_ser_pkg::*;
#(
   parameter int SLOT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] half,
   input  fmt_e             fmt,
   output logic             bck,
   output logic             fall_evt,
   output logic             slot_start,
   output logic             lrck_lvl
);
   localparam int POS_W = $clog2(SLOT_W) + 1;

   logic [DIV_W-1:0] div_q;
   logic [POS_W-1:0] pos_q, pos_n;
   logic             tick;

   always_comb begin
      tick       = (div_q == half - 1'b1);
      fall_evt   = tick & bck;
      pos_n      = pos_q + 1'b1;
      slot_start = (pos_n[POS_W-2:0] == '0);
      lrck_lvl   = pos_n[POS_W-1] ? ~left_level(fmt) : left_level(fmt);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         div_q <= '0;
         bck   <= 1'b0;
         pos_q <= '1;
      end else begin
         if (tick) begin
            div_q <= '0;
            bck   <= ~bck;
         end else begin
            div_q <= div_q + 1'b1;
         end
         if (fall_evt) pos_q <= pos_n;
      end
   end

endmodule

// File: rtl/aud_ser_slv_sync.sv
module aud_ser_slv_sync #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ext_bck,
   input  logic ext_lrck,
   output logic evt,
   output logic slot_start,
   output logic lrck_lvl
);
   logic [SYNC_STAGES-1:0] bck_sh, lr_sh;
   logic bck_d, lrck_prev_q, armed_q, fall;

   always_comb begin
      fall       = bck_d & ~bck_sh[SYNC_STAGES-1];
      evt        = fall & armed_q;
      lrck_lvl   = lr_sh[SYNC_STAGES-1];
      slot_start = lrck_lvl ^ lrck_prev_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bck_sh      <= '0;
         lr_sh       <= '0;
         bck_d       <= 1'b0;
         lrck_prev_q <= 1'b0;
         armed_q     <= 1'b0;
      end else begin
         bck_sh <= {bck_sh[SYNC_STAGES-2:0], ext_bck};
         lr_sh  <= {lr_sh[SYNC_STAGES-2:0], ext_lrck};
         bck_d  <= bck_sh[SYNC_STAGES-1];
         if (fall) begin
            armed_q     <= 1'b1;
            lrck_prev_q <= lrck_lvl;
         end
      end
   end

endmodule

// File: rtl/aud_ser_slot_eng.sv
module aud_ser_slot_eng
   import aud_ser_pkg::*;
#(
   parameter int SAMPLE_W = 24,
   parameter int SLOT_W   = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  fmt_e                fmt,
   input  logic                master,
   input  logic                evt,
   input  logic                slot_start,
   input  logic                lrck_lvl,
   input  logic [SAMPLE_W-1:0] hold_l,
   input  logic [SAMPLE_W-1:0] hold_r,
   output logic                sdata,
   output logic                lrck
);
   localparam int K_W   = $clog2(SLOT_W);
   localparam int LEN_W = K_W + 1;

   logic [K_W-1:0]      k_q, k_n;
   logic [LEN_W-1:0]    len_q, len_n;
   logic [SAMPLE_W-1:0] fl_q, fr_q, fl_n, fr_n, word, shifted;
   logic                left_n, bit_n;
   int                  off, idx;

   always_comb begin
      k_n    = slot_start ? '0 : ((k_q == K_W'(SLOT_W-1)) ? k_q : k_q + 1'b1);
      len_n  = slot_start ? ({1'b0, k_q} + 1'b1) : len_q;
      left_n = (lrck_lvl == left_level(fmt));
      fl_n   = (slot_start && left_n) ? hold_l : fl_q;
      fr_n   = (slot_start && left_n) ? hold_r : fr_q;
      word   = left_n ? fl_n : fr_n;
      case (fmt)
         FMT_I2S: off = 1;
         FMT_RJ:  off = (int'(len_n) > SAMPLE_W) ? int'(len_n) - SAMPLE_W : 0;
         default: off = 0;
      endcase
      idx     = int'(k_n) - off;
      shifted = word << idx;
      bit_n   = 1'b0;
      if (idx >= 0 && idx < SAMPLE_W) bit_n = shifted[SAMPLE_W-1];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         k_q   <= K_W'(SLOT_W-1);
         len_q <= LEN_W'(SLOT_W);
         fl_q  <= '0;
         fr_q  <= '0;
         sdata <= 1'b0;
         lrck  <= 1'b0;
      end else if (evt) begin
         k_q   <= k_n;
         len_q <= len_n;
         fl_q  <= fl_n;
         fr_q  <= fr_n;
         sdata <= bit_n;
         lrck  <= lrck_lvl;
      end
   end

   AST_MASTER_FULL_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
      (evt && slot_start && master) |-> (k_q == K_W'(SLOT_W-1))); // R2

   AST_FRAME_AT_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
      (evt && !(slot_start && left_n)) |=> $stable(fl_q) && $stable(fr_q)); // R7

endmodule

// File: rtl/aud_ser_dsd.sv
module aud_ser_dsd (
   input  logic clk,
   input  logic rst_n,
   input  logic evt,
   input  logic in_l,
   input  logic in_r,
   output logic out_l,
   output logic out_r
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_l <= 1'b0;
         out_r <= 1'b0;
      end else if (evt) begin
         out_l <= in_l;
         out_r <= in_r;
      end
   end
endmodule

// File: rtl/aud_ser_tx.sv
module aud_ser_tx
   import aud_ser_pkg::*;
#(
   parameter int SAMPLE_W    = 24,
   parameter int SLOT_W      = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [1:0]          fmt_sel,
   input  logic                slave_sel,
   input  logic [2:0]          rate_sel,
   input  logic [SAMPLE_W-1:0] smp_left,
   input  logic [SAMPLE_W-1:0] smp_right,
   input  logic                smp_valid,
   input  logic                ext_bck_i,
   input  logic                ext_lrck_i,
   output logic                lrck_o,
   output logic                bck_o,
   output logic                sdata_o,
   output logic                clk_oe_o
);
   generate
      if (SAMPLE_W > SLOT_W) begin : g_bad_width
         $error("SAMPLE_W must not exceed SLOT_W");
      end
      if ((1 << $clog2(SLOT_W)) != SLOT_W) begin : g_bad_slot
         $error("SLOT_W must be a power of two");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   cfg_t                cfg_q;
   logic [SAMPLE_W-1:0] hold_l, hold_r;
   logic                is_dsd, use_slave;
   logic                m_bck, m_evt, m_start, m_lvl;
   logic                s_evt, s_start, s_lvl;
   logic                e_evt, e_start, e_lvl, e_data, e_lrck;
   logic                d_l, d_r;

   always_ff @(posedge clk) begin
      if (!rst_n) cfg_q <= '{fmt: fmt_e'(fmt_sel), slave: slave_sel, rate: rate_sel};
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hold_l <= '0;
         hold_r <= '0;
      end else if (smp_valid) begin
         hold_l <= smp_left;
         hold_r <= smp_right;
      end
   end

   always_comb begin
      is_dsd    = (cfg_q.fmt == FMT_DSD);
      use_slave = cfg_q.slave & ~is_dsd;
      e_evt     = (use_slave ? s_evt : m_evt) & ~is_dsd;
      e_start   = use_slave ? s_start : m_start;
      e_lvl     = use_slave ? s_lvl : m_lvl;
   end

   aud_ser_clkgen #(.SLOT_W(SLOT_W)) u_clkgen (
      .clk        (clk),
      .rst_n      (rst_n),
      .half       (half_of_code(cfg_q.rate)),
      .fmt        (cfg_q.fmt),
      .bck        (m_bck),
      .fall_evt   (m_evt),
      .slot_start (m_start),
      .lrck_lvl   (m_lvl)
   );

   aud_ser_slv_sync #(.SYNC_STAGES(SYNC_STAGES)) u_slv (
      .clk        (clk),
      .rst_n      (rst_n),
      .ext_bck    (ext_bck_i),
      .ext_lrck   (ext_lrck_i),
      .evt        (s_evt),
      .slot_start (s_start),
      .lrck_lvl   (s_lvl)
   );

   aud_ser_slot_eng #(.SAMPLE_W(SAMPLE_W), .SLOT_W(SLOT_W)) u_eng (
      .clk        (clk),
      .rst_n      (rst_n),
      .fmt        (cfg_q.fmt),
      .master     (~use_slave),
      .evt        (e_evt),
      .slot_start (e_start),
      .lrck_lvl   (e_lvl),
      .hold_l     (hold_l),
      .hold_r     (hold_r),
      .sdata      (e_data),
      .lrck       (e_lrck)
   );

   aud_ser_dsd u_dsd (
      .clk   (clk),
      .rst_n (rst_n),
      .evt   (m_evt & is_dsd),
      .in_l  (smp_left[0]),
      .in_r  (smp_right[0]),
      .out_l (d_l),
      .out_r (d_r)
   );

   always_comb begin
      clk_oe_o = ~use_slave;
      lrck_o   = use_slave ? 1'b0 : (is_dsd ? m_bck : e_lrck);
      bck_o    = use_slave ? 1'b0 : (is_dsd ? d_l : m_bck);
      sdata_o  = is_dsd ? d_r : e_data;
   end

   AST_DATA_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !use_slave && !is_dsd && !$stable(sdata_o)) |-> $fell(bck_o)); // R6

   AST_LRCK_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !use_slave && !is_dsd && !$stable(lrck_o)) |-> $fell(bck_o)); // R6

   AST_DSD_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && is_dsd && (!$stable(bck_o) || !$stable(sdata_o))) |-> $fell(lrck_o)); // R9

   AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> $stable(cfg_q)); // R10

endmodule

// File: tb/aud_ser_tx_tb.sv
module aud_ser_tx_tb;
   localparam int CLK_P = 10;
   localparam int SH    = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  fmt_sel = 2'b00;
   logic        slave_sel = 1'b0;
   logic [2:0]  rate_sel = 3'd0;
   logic [23:0] smp_left = '0, smp_right = '0;
   logic        smp_valid = 1'b0;
   logic        ext_bck_i = 1'b1, ext_lrck_i = 1'b0;
   logic        lrck_o, bck_o, sdata_o, clk_oe_o;

   aud_ser_tx u_dut (
      .clk(clk), .rst_n(rst_n), .fmt_sel(fmt_sel), .slave_sel(slave_sel),
      .rate_sel(rate_sel), .smp_left(smp_left), .smp_right(smp_right),
      .smp_valid(smp_valid), .ext_bck_i(ext_bck_i), .ext_lrck_i(ext_lrck_i),
      .lrck_o(lrck_o), .bck_o(bck_o), .sdata_o(sdata_o), .clk_oe_o(clk_oe_o)
   );

   always #(CLK_P/2) clk = ~clk;

   int   n_chk = 0, n_fail = 0;
   logic prev_b = 1'b1;
   int   gap = 0;

   // fields: fmt[56:55] rate[54:52] left[51:28] right[27:4] half[3:0]
   localparam logic [56:0] VEC [7] = '{
      {2'b00, 3'd0, 24'h800001, 24'h7FFFFE, 4'd6},
      {2'b01, 3'd1, 24'hC35A96, 24'h123457, 4'd4},
      {2'b10, 3'd2, 24'hFFFFFF, 24'h000001, 4'd3},
      {2'b00, 3'd3, 24'h5A5A5A, 24'hA5A5A5, 4'd2},
      {2'b01, 3'd4, 24'h800000, 24'hFFFFFF, 4'd3},
      {2'b10, 3'd5, 24'h0F0F0F, 24'hF0F0F1, 4'd2},
      {2'b00, 3'd6, 24'h000001, 24'h800000, 4'd1}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] exp_slot(input logic [1:0] f, input logic [23:0] s);
      case (f)
         2'b00:   return {s, 8'h00};
         2'b01:   return {1'b0, s, 7'h00};
         default: return {8'h00, s};
      endcase
   endfunction

   function automatic string req_of(input logic [1:0] f);
      case (f)
         2'b00:   return "R3";
         2'b01:   return "R4";
         default: return "R5";
      endcase
   endfunction

   task automatic do_reset(input logic [1:0] f, input logic s, input logic [2:0] r);
      rst_n = 1'b0; fmt_sel = f; slave_sel = s; rate_sel = r; smp_valid = 1'b0;
      repeat (4) @(negedge clk);
      chk("R1 pins in reset", {29'b0, lrck_o, bck_o, sdata_o}, 32'h0);
      rst_n = 1'b1;
   endtask

   task automatic load(input logic [23:0] l, input logic [23:0] r);
      smp_left = l; smp_right = r; smp_valid = 1'b1;
      @(negedge clk);
      smp_valid = 1'b0;
   endtask

   // receiver: next rising bck_o seen at a falling system clock edge (R6 sampling point)
   task automatic next_rise(output logic d, output logic l);
      bit found;
      found = 1'b0;
      gap = 0;
      while (!found) begin
         @(negedge clk);
         smp_valid = 1'b0;
         gap++;
         if (bck_o && !prev_b) begin
            found = 1'b1;
            d = sdata_o;
            l = lrck_o;
         end
         prev_b = bck_o;
      end
   endtask

   task automatic m_capture(input logic llvl, input bit inject, input logic [23:0] il,
                            input logic [23:0] ir, output logic [31:0] ls,
                            output logic [31:0] rs, output int per);
      logic d, l, pl;
      pl = llvl;
      next_rise(d, l);
      while (!(l == llvl && pl != llvl)) begin
         pl = l;
         next_rise(d, l);
      end
      ls = {31'b0, d};
      for (int i = 1; i < 32; i++) begin
         if (inject && i == 10) begin
            smp_left = il; smp_right = ir; smp_valid = 1'b1;
         end
         next_rise(d, l);
         ls = {ls[30:0], d};
      end
      rs = '0;
      for (int i = 0; i < 32; i++) begin
         next_rise(d, l);
         rs = {rs[30:0], d};
      end
      per = gap;
   endtask

   task automatic s_frames(input int nbits, input int nfr, input logic llvl,
                           output logic [31:0] ls, output logic [31:0] rs);
      logic [31:0] acc;
      ls = '0; rs = '0;
      for (int f = 0; f < nfr; f++) begin
         for (int ch = 0; ch < 2; ch++) begin
            acc = '0;
            for (int b = 0; b < nbits; b++) begin
               ext_bck_i = 1'b0;
               if (b == 0) ext_lrck_i = (ch == 0) ? llvl : ~llvl;
               repeat (SH) @(negedge clk);
               acc = {acc[30:0], sdata_o};
               ext_bck_i = 1'b1;
               repeat (SH) @(negedge clk);
            end
            if (ch == 0) ls = acc; else rs = acc;
         end
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      logic [31:0] ls, rs;
      int per;
      logic [1:0] f;
      logic [23:0] vl, vr;
      logic pd;

      // table walk: format, rate, slot contents and bit-clock period
      for (int v = 0; v < 7; v++) begin
         f  = VEC[v][56:55];
         vl = VEC[v][51:28];
         vr = VEC[v][27:4];
         do_reset(f, 1'b0, VEC[v][54:52]);
         load(vl, vr);
         m_capture(f != 2'b01, 1'b0, '0, '0, ls, rs, per);
         chk({req_of(f), " R6 left slot"}, ls, exp_slot(f, vl));
         chk({req_of(f), " R6 right slot"}, rs, exp_slot(f, vr));
         chk("R2 bit clock period", 32'(per), 32'(2 * VEC[v][3:0]));
      end

      // R7: pair arriving mid left slot waits for next left slot
      do_reset(2'b00, 1'b0, 3'd3);
      load(24'h111111, 24'h222222);
      m_capture(1'b1, 1'b1, 24'h333333, 24'h444444, ls, rs, per);
      chk("R7 left holds old pair", ls, exp_slot(2'b00, 24'h111111));
      chk("R7 right holds old pair", rs, exp_slot(2'b00, 24'h222222));
      m_capture(1'b1, 1'b0, '0, '0, ls, rs, per);
      chk("R7 new pair left", ls, exp_slot(2'b00, 24'h333333));
      chk("R7 new pair right", rs, exp_slot(2'b00, 24'h444444));

      // R10: configuration pins changed outside reset are ignored
      do_reset(2'b00, 1'b0, 3'd3);
      load(24'hABCDEF, 24'h13579B);
      repeat (5) @(negedge clk);
      fmt_sel = 2'b01; rate_sel = 3'd0; slave_sel = 1'b1;
      m_capture(1'b1, 1'b0, '0, '0, ls, rs, per);
      chk("R10 format kept", ls, exp_slot(2'b00, 24'hABCDEF));
      chk("R10 rate kept", 32'(per), 32'd4);
      chk("R10 still master", {31'b0, clk_oe_o}, 32'd1);

      // R8 and R5: slave right-justified with 24-bit slots
      ext_bck_i = 1'b1; ext_lrck_i = 1'b0;
      do_reset(2'b10, 1'b1, 3'd0);
      load(24'h9ABCDE, 24'h765432);
      s_frames(24, 3, 1'b1, ls, rs);
      chk("R5 R8 slave 24-bit left", ls, {8'h00, 24'h9ABCDE});
      chk("R5 R8 slave 24-bit right", rs, {8'h00, 24'h765432});
      chk("R8 clock pins idle", {29'b0, clk_oe_o, lrck_o, bck_o}, 32'h0);

      // R8 and R4: slave I2S with 32-bit slots
      ext_bck_i = 1'b1; ext_lrck_i = 1'b1;
      do_reset(2'b01, 1'b1, 3'd0);
      load(24'h800001, 24'h3C3C3C);
      s_frames(32, 3, 1'b0, ls, rs);
      chk("R4 R8 slave i2s left", ls, exp_slot(2'b01, 24'h800001));
      chk("R4 R8 slave i2s right", rs, exp_slot(2'b01, 24'h3C3C3C));

      // R9: one-bit stream mode, slave request overridden
      do_reset(2'b11, 1'b1, 3'd7);
      smp_left = 24'h000001; smp_right = 24'h000000;
      repeat (10) @(negedge clk);
      chk("R9 drives clocks", {31'b0, clk_oe_o}, 32'd1);
      pd = lrck_o;
      while (!(lrck_o && !pd)) begin pd = lrck_o; @(negedge clk); end
      chk("R9 left bit 1", {30'b0, bck_o, sdata_o}, 32'h2);
      per = 0; pd = lrck_o;
      do begin pd = lrck_o; @(negedge clk); per++; end while (!(lrck_o && !pd));
      chk("R9 stream clock period", 32'(per), 32'd2);
      smp_left = 24'h000000; smp_right = 24'h000001;
      repeat (6) @(negedge clk);
      pd = lrck_o;
      while (!(lrck_o && !pd)) begin pd = lrck_o; @(negedge clk); end
      chk("R9 right bit 1", {30'b0, bck_o, sdata_o}, 32'h1);

      do_reset(2'b00, 1'b0, 3'd0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule